// File: doc/BRIEF.md
# Real-Time Clock Alarm and Update Interrupt Unit

This block sits beside a real-time clock's time-keeping counters and turns their once-per-second update into interrupt events. On every update strobe it raises an update-ended flag. It also compares the freshly updated seconds, minutes and hours against three programmable alarm bytes, and raises an alarm flag when they match. An alarm byte whose two top bits are both set is a wildcard and matches any value of its field. The hour comparison uses the same 12/24-hour and BCD/binary rules as the current hour, including the PM bit.

The flags are held in a status byte. Reading the status byte returns it and clears it. A single level interrupt request is raised when a flag that has just been set is also enabled in the configuration byte. Writing the configuration byte re-evaluates the request straight away against flags that are already pending. While the clock's divider is held in reset, update strobes have no effect.

Top module: `rtcalm_unit`

## Requirements
- R1: An alarm byte with bits [7:6] = 2'b11 is a wildcard and matches every value of its field; with all three alarm bytes wildcards, every update sets the alarm flag.
- R2: On an update, the alarm flag (status bit 5) is set when every non-wildcard alarm field equals the current time field, and it is left unchanged otherwise.
- R3: Every update strobe taken while the divider is not held sets the update-ended flag (status bit 4).
- R4: Field values are decoded before comparison. Configuration bit 2 = 1 selects binary, 0 selects BCD. Configuration bit 1 = 1 selects 24-hour mode. In 12-hour mode the hour bit 7 is PM, and the hour is taken modulo 12 before PM adds 12, so that 12 AM equals hour 0.
- R5: The request bit (status bit 7) and the `irq` output are set on an update only when a flag newly set by that update has its enable set: configuration bit 5 for alarm, bit 4 for update-ended. A flag set without its enable, or a flag that was already set, raises nothing.
- R6: A configuration write sets the request bit and `irq` in the next cycle when a pending flag has its enable set in the written value, and clears both otherwise. The flags themselves are kept.
- R7: While `div_hold` is 1, an update strobe changes no flag and no request.
- R8: A status read returns the status byte as it was before the read, then clears all flags, the request bit and `irq`.
- R9: After reset the status byte is 0, `irq` is 0 and the configuration byte is 8'h02, with all enables cleared. Alarm bytes reset to 0.
- R10: When a read and an update fall in the same cycle, the read returns the old status and the flags from the update remain set afterwards.
- R11: Alarm writes select the seconds, minutes or hours byte with `alm_sel` = 0, 1 or 2. A write with `alm_sel` = 3 changes no alarm byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_tick | input | 1 | One-cycle once-per-second update strobe |
| div_hold | input | 1 | Divider held in reset; suppresses update events |
| cur_sec | input | 8 | Current seconds, encoded per configuration |
| cur_min | input | 8 | Current minutes, encoded per configuration |
| cur_hour | input | 8 | Current hours, encoded per configuration |
| alm_we | input | 1 | Alarm byte write strobe |
| alm_sel | input | 2 | Alarm byte select: 0 seconds, 1 minutes, 2 hours |
| alm_wdata | input | 8 | Alarm byte write data |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration byte contents |
| stat_rd | input | 1 | Status read strobe; clears the status after this cycle |
| stat_rdata | output | 8 | Status byte: bit 7 request, bit 5 alarm, bit 4 update-ended |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest state to reach is a pending flag whose enable is off while the request is low. Enabling that flag with a configuration write must then fire the request with no update strobe at all. The stimulus gets there by taking an update with all enables clear, then writing the configuration byte with only the matching enable. A second write removes the enable to check that the request drops while the flag stays. Hour decoding corners are driven through non-canonical codes, for example hour 0 against an alarm of 12 AM in 12-hour BCD mode. The bench also drives a read in the same cycle as an update.

// File: rtl/rtcalm_pkg.sv
package rtcalm_pkg;
    localparam int DW       = 8;
    localparam int NFIELD   = 3;
    localparam int SELW     = 2;

    // status byte bit positions
    localparam int ST_REQ   = 7;
    localparam int ST_ALM   = 5;
    localparam int ST_UPD   = 4;
    // configuration byte bit positions
    localparam int CF_AEN   = 5;
    localparam int CF_UEN   = 4;
    localparam int CF_BIN   = 2;
    localparam int CF_H24   = 1;
    localparam logic [DW-1:0] CFG_RST = 8'h02;

    typedef enum logic [SELW-1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_NONE = 2'd3
    } field_e;

    typedef struct packed {
        logic req;
        logic alm;
        logic upd;
    } flags_t;

    typedef logic [NFIELD-1:0][DW-1:0] tvec_t;

    function automatic logic is_wild(input logic [DW-1:0] b);
        return b[7:6] == 2'b11;
    endfunction

    function automatic logic [DW-1:0] code_val(input logic [DW-1:0] b, input logic bin);
        logic [DW-1:0] v;
        v = ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
        return bin ? b : v;
    endfunction

    function automatic logic [DW-1:0] hour_val(input logic [DW-1:0] b, input logic bin,
                                               input logic h24);
        logic [DW-1:0] v;
        v = code_val({1'b0, b[6:0]}, bin) % 8'd12;
        if (h24) return code_val(b, bin);
        return v + (b[7] ? 8'd12 : 8'd0);
    endfunction
endpackage

// File: rtl/rtcalm_alarm_store.sv
module rtcalm_alarm_store
    import rtcalm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   wdata,
    output tvec_t           alarm
);
    for (genvar g = 0; g < NFIELD; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)                                   alarm[g] <= '0;
            else if (we && sel == SELW'(g))            alarm[g] <= wdata;
        end
    end
endmodule

// File: rtl/rtcalm_match.sv
module rtcalm_match
    import rtcalm_pkg::*;
(
    input  tvec_t   alarm,
    input  tvec_t   cur,
    input  logic    bin,
    input  logic    h24,
    output logic    hit
);
    logic [NFIELD-1:0] fld_hit;

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        logic [DW-1:0] a_v, c_v;
        if (g == int'(FLD_HOUR)) begin : g_hour
            assign a_v = hour_val(alarm[g], bin, h24);
            assign c_v = hour_val(cur[g], bin, h24);
        end else begin : g_plain
            assign a_v = code_val(alarm[g], bin);
            assign c_v = code_val(cur[g], bin);
        end
        assign fld_hit[g] = is_wild(alarm[g]) || (a_v == c_v);
    end

    assign hit = &fld_hit;
endmodule

// File: rtl/rtcalm_flags.sv
module rtcalm_flags
    import rtcalm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_tick,
    input  logic          div_hold,
    input  logic          alarm_hit,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          stat_rd,
    output logic [DW-1:0] cfg_q,
    output logic [DW-1:0] stat_rdata,
    output logic          irq
);
    flags_t        f_q, f_d;
    logic [DW-1:0] cfg_d;
    logic [1:0]    en_d, pend, fresh;
    logic          upd_ev;

    assign upd_ev = upd_tick && !div_hold;

    always_comb begin
        f_d   = f_q;
        cfg_d = cfg_we ? cfg_wdata : cfg_q;
        en_d  = {cfg_d[CF_AEN], cfg_d[CF_UEN]};
        if (stat_rd) f_d = '0;
        pend  = {f_d.alm, f_d.upd};
        if (cfg_we) f_d.req = |(en_d & pend);
        fresh = '0;
        if (upd_ev) begin
            fresh   = {alarm_hit, 1'b1} & ~pend;
            f_d.alm = f_d.alm | alarm_hit;
            f_d.upd = 1'b1;
            if (|(fresh & en_d)) f_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q   <= '0;
            cfg_q <= CFG_RST;
        end else begin
            f_q   <= f_d;
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        stat_rdata         = '0;
        stat_rdata[ST_REQ] = f_q.req;
        stat_rdata[ST_ALM] = f_q.alm;
        stat_rdata[ST_UPD] = f_q.upd;
    end
    assign irq = f_q.req;

    p_uf_on_update_r3: assert property (@(posedge clk) disable iff (rst)
        upd_ev |=> stat_rdata[ST_UPD]);
    p_hold_freezes_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && div_hold && !stat_rd && !cfg_we) |=> $stable(stat_rdata));
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !upd_ev) |=> (stat_rdata == '0 && !irq));
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> |({cfg_q[CF_AEN], cfg_q[CF_UEN]} & {stat_rdata[ST_ALM], stat_rdata[ST_UPD]}));
    p_enable_fires_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !stat_rd && |({cfg_wdata[CF_AEN], cfg_wdata[CF_UEN]} &
                                 {stat_rdata[ST_ALM], stat_rdata[ST_UPD]})) |=> irq);
    p_reset_state_r9: assert property (@(posedge clk)
        $past(rst) |-> (stat_rdata == '0 && cfg_q == CFG_RST && !irq));
endmodule

// File: rtl/rtcalm_unit.sv
module rtcalm_unit
    import rtcalm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_tick,
    input  logic            div_hold,
    input  logic [DW-1:0]   cur_sec,
    input  logic [DW-1:0]   cur_min,
    input  logic [DW-1:0]   cur_hour,
    input  logic            alm_we,
    input  logic [SELW-1:0] alm_sel,
    input  logic [DW-1:0]   alm_wdata,
    input  logic            cfg_we,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    input  logic            stat_rd,
    output logic [DW-1:0]   stat_rdata,
    output logic            irq
);
    tvec_t alarm, cur;
    logic  hit;

    assign cur[FLD_SEC]  = cur_sec;
    assign cur[FLD_MIN]  = cur_min;
    assign cur[FLD_HOUR] = cur_hour;

    rtcalm_alarm_store u_store (
        .clk(clk), .rst(rst), .we(alm_we), .sel(alm_sel),
        .wdata(alm_wdata), .alarm(alarm)
    );

    rtcalm_match u_match (
        .alarm(alarm), .cur(cur),
        .bin(cfg_rdata[CF_BIN]), .h24(cfg_rdata[CF_H24]), .hit(hit)
    );

    rtcalm_flags u_flags (
        .clk(clk), .rst(rst), .upd_tick(upd_tick), .div_hold(div_hold),
        .alarm_hit(hit), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stat_rd(stat_rd), .cfg_q(cfg_rdata), .stat_rdata(stat_rdata), .irq(irq)
    );

    p_wild_match_r1: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && !div_hold && is_wild(alarm[0]) && is_wild(alarm[1]) &&
         is_wild(alarm[2])) |=> stat_rdata[ST_ALM]);
endmodule

// File: tb/rtcalm_unit_bench.sv
module rtcalm_unit_bench;
    logic       clk = 0, rst = 1;
    logic       upd_tick = 0, div_hold = 0, alm_we = 0, cfg_we = 0, stat_rd = 0;
    logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, alm_wdata = 0, cfg_wdata = 0;
    logic [1:0] alm_sel = 0;
    logic [7:0] cfg_rdata, stat_rdata;
    logic       irq;

    int    n_chk = 0, n_fail = 0;
    string tag = "R9";
    bit    done = 0;

    // reference state
    int m_alm[3];
    int m_cfg = 8'h02;
    bit m_af, m_uf, m_req;

    always #5 clk = ~clk;

    rtcalm_unit u_rtcalm_unit (
        .clk(clk), .rst(rst), .upd_tick(upd_tick), .div_hold(div_hold),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .alm_we(alm_we), .alm_sel(alm_sel), .alm_wdata(alm_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .irq(irq)
    );

    function automatic int dec(int v, int cfg);
        if ((cfg & 4) != 0) return v;
        return (v / 16) * 10 + (v % 16);
    endfunction

    function automatic int hr(int v, int cfg);
        int h;
        if ((cfg & 2) != 0) return dec(v, cfg);
        h = dec(v % 128, cfg) % 12;
        if (v >= 128) h += 12;
        return h;
    endfunction

    function automatic bit fmatch(int a, int c, int cfg, bit is_hour);
        if (a / 64 == 3) return 1;
        return is_hour ? (hr(a, cfg) == hr(c, cfg)) : (dec(a, cfg) == dec(c, cfg));
    endfunction

    function automatic int m_stat();
        return (m_req ? 128 : 0) + (m_af ? 32 : 0) + (m_uf ? 16 : 0);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference model, compared on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_af = 0; m_uf = 0; m_req = 0; m_cfg = 8'h02;
            m_alm[0] = 0; m_alm[1] = 0; m_alm[2] = 0;
        end else begin
            bit hit, fa, fu;
            int en;
            hit = fmatch(m_alm[0], cur_sec, m_cfg, 0) && fmatch(m_alm[1], cur_min, m_cfg, 0)
                  && fmatch(m_alm[2], cur_hour, m_cfg, 1);
            if (stat_rd) begin m_af = 0; m_uf = 0; m_req = 0; end
            if (cfg_we) m_cfg = cfg_wdata;
            en = m_cfg;
            if (cfg_we) m_req = ((en & 32) != 0 && m_af) || ((en & 16) != 0 && m_uf);
            if (upd_tick && !div_hold) begin
                fa = hit && !m_af;
                fu = !m_uf;
                m_af = m_af | hit;
                m_uf = 1;
                if ((fa && (en & 32) != 0) || (fu && (en & 16) != 0)) m_req = 1;
            end
            if (alm_we && alm_sel < 3) m_alm[alm_sel] = alm_wdata;
        end
        #2;
        check({tag, " model stat"}, stat_rdata, m_stat());
        check({tag, " model irq"}, irq, m_req);
        check({tag, " model cfg"}, cfg_rdata, m_cfg);
    end

    task automatic cyc();
        @(negedge clk);
        upd_tick = 0; alm_we = 0; cfg_we = 0; stat_rd = 0;
    endtask
    task automatic wr_alarm(int sel, int v);
        alm_we = 1; alm_sel = 2'(sel); alm_wdata = 8'(v); cyc();
    endtask
    task automatic wr_cfg(int v);
        cfg_we = 1; cfg_wdata = 8'(v); cyc();
    endtask
    task automatic tick(int h, int m, int s);
        cur_hour = 8'(h); cur_min = 8'(m); cur_sec = 8'(s); upd_tick = 1; cyc();
    endtask
    task automatic rd(string req, int exp);
        check(req, stat_rdata, exp); stat_rd = 1; cyc();
        check(req, stat_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; @(negedge clk);
        check("R9 stat", stat_rdata, 0);
        check("R9 irq", irq, 0);
        check("R9 cfg", cfg_rdata, 8'h02);

        tag = "R3"; tick(8'h01, 8'h02, 8'h03);
        check("R3 uf", stat_rdata, 8'h10);
        check("R5 no enable", irq, 0);
        rd("R8 read", 8'h10);

        tag = "R2"; wr_alarm(0, 8'h30); wr_alarm(1, 8'h20); wr_alarm(2, 8'h10);
        tick(8'h10, 8'h20, 8'h30);
        rd("R2 match", 8'h30);
        tick(8'h10, 8'h20, 8'h31);
        rd("R2 miss", 8'h10);

        tag = "R11"; wr_alarm(3, 8'h45); tick(8'h10, 8'h20, 8'h30);
        rd("R11 sel3 ignored", 8'h30);

        tag = "R1"; wr_alarm(0, 8'hC0); tick(8'h10, 8'h20, 8'h45);
        rd("R1 sec wild", 8'h30);
        wr_alarm(1, 8'hFF); wr_alarm(2, 8'hC3); tick(8'h07, 8'h59, 8'h12);
        rd("R1 all wild", 8'h30);

        tag = "R5"; wr_alarm(0, 8'h05); wr_alarm(1, 8'hC0); wr_alarm(2, 8'hC0);
        wr_cfg(8'h22);
        tick(8'h00, 8'h00, 8'h04);
        check("R5 uf not enabled", irq, 0);
        tick(8'h00, 8'h00, 8'h05);
        check("R5 af enabled", stat_rdata, 8'hB0);
        check("R5 irq", irq, 1);
        rd("R8 clear", 8'hB0);
        check("R8 irq low", irq, 0);
        wr_cfg(8'h02);
        tick(8'h00, 8'h00, 8'h05);
        wr_cfg(8'h02);
        tick(8'h00, 8'h00, 8'h05);
        check("R5 stale flag", irq, 0);

        tag = "R6"; wr_cfg(8'h12);
        check("R6 fire", irq, 1);
        check("R6 stat", stat_rdata, 8'hB0);
        wr_cfg(8'h02);
        check("R6 drop", irq, 0);
        check("R6 flags kept", stat_rdata, 8'h30);
        rd("R6 read", 8'h30);

        tag = "R7"; div_hold = 1; wr_cfg(8'h32);
        tick(8'h00, 8'h00, 8'h05);
        check("R7 hold", stat_rdata, 0);
        check("R7 irq", irq, 0);
        div_hold = 0;

        tag = "R4"; wr_cfg(8'h00);
        wr_alarm(0, 8'hC0); wr_alarm(1, 8'hC0); wr_alarm(2, 8'h12);
        tick(8'h00, 8'h00, 8'h00);
        rd("R4 12AM eq 0", 8'h30);
        wr_alarm(2, 8'h92); tick(8'h12, 8'h00, 8'h00);
        rd("R4 PM differs", 8'h10);
        tick(8'h92, 8'h00, 8'h00);
        rd("R4 PM matches", 8'h30);
        wr_cfg(8'h02); wr_alarm(2, 8'h10); tick(8'h0A, 8'h00, 8'h00);
        rd("R4 bcd nonstd", 8'h30);
        wr_cfg(8'h06); tick(8'h0A, 8'h00, 8'h00);
        rd("R4 binary", 8'h10);

        tag = "R10"; wr_cfg(8'h02); tick(8'h00, 8'h00, 8'h00);
        check("R10 pre", stat_rdata, 8'h10);
        wr_alarm(2, 8'hC0);
        stat_rd = 1; cur_hour = 0; upd_tick = 1; cyc();
        check("R10 after", stat_rdata, 8'h30);

        tag = "R9"; rst = 1; cyc(); rst = 0; cyc();
        check("R9 again", stat_rdata, 0);
        check("R9 cfg again", cfg_rdata, 8'h02);

        done = 1;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule